// File: doc/BRIEF.md
# Dual-Source Blink Rate Generator

This block produces four blink square waves for a sixteen-channel output driver. Each wave serves one group of four neighbouring outputs. A small register file holds a 2-bit rate code for each group and a reference word. In the reference word, one bit picks the time base shared by all four groups. That time base is either an external blink clock input or the block's own system clock, and a 2-bit field names where the system clock comes from.

All four groups read taps of one free-running counter, so their edges line up and every wave has a 50% duty cycle. On the external time base the counter steps once per synchronized rising edge of the blink input. On the system clock it steps every cycle, and the taps sit high in the chain to give very slow blink rates. When the system-clock source field says "no clock" or holds the reserved value while the system clock is the time base, the chain stops and all blink outputs are held low.

Top module: `flash_rate_gen`

## Requirements
- R1: A synchronous active-low reset clears both registers (reads of 0x18 and 0x19 return 0x00), clears the counter and drives all four blink outputs low.
- R2: A write to address 0x18 stores all eight bits, and they read back unchanged. Group g (pins 4g+1..4g+4) takes its rate code from bits 2g+1:2g.
- R3: Address 0x19 keeps bit 0 (time base: 0 = external blink input, 1 = system clock) and bits 3:2 (system clock source: 00 pin, 01 internal oscillator, 10 none, 11 reserved). Bits 7:4 and bit 1 always read as 0, and writes to them have no effect.
- R4: With the external time base, the input passes through two sync flops. Code 00 drives the group output with the synchronized level. Codes 01, 10 and 11 divide the synchronized rising-edge rate by 2, 4 and 16.
- R5: With the system clock as the time base and source 00 or 01, codes 00, 01, 10 and 11 give a blink period of 2^(B+1), 2^(B+2), 2^(B+3) and 2^(B+5) clock cycles, where B is parameter SYS_BASE (default 18, giving divide ratios of 2^19..2^23).
- R6: All groups read the same counter, so two groups that hold the same rate code always drive the same level.
- R7: Writing a new rate code or a new time base does not reset the counter. The counter keeps counting through the write.
- R8: When the time base is the system clock and the source field is 10 or 11, the counter holds its value and all blink outputs stay low.
- R9: A write to any address other than 0x18 and 0x19 changes no register, and a read of such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| ext_flash_in | input | 1 | External blink reference, asynchronous |
| flash_out | output | 4 | Blink waves, bit g serves pin group g |

## Verification
The rate word 0xE4 sets all four codes at once, so every divide ratio of the active time base is compared against the model in the same cycles. This separates a tap-index fault from a group-wiring fault. The external input is driven with a regular square wave and then with an irregular burst of pulses. The regular wave shows the divide-by-2, 4 and 16 ratios. The irregular burst exposes faults in edge detection and synchronizer depth that a steady wave can hide. The system-clock runs, the halting source codes and the writes made while the counter is running show whether the chain is held, released or wrongly cleared.

// File: rtl/flash_rate_pkg.sv
package flash_rate_pkg;

  typedef enum logic [1:0] {
    CSRC_PIN  = 2'b00,
    CSRC_OSC  = 2'b01,
    CSRC_NONE = 2'b10,
    CSRC_RSVD = 2'b11
  } clk_src_e;

  localparam logic [7:0] RATE_ADDR = 8'h18;
  localparam logic [7:0] REF_ADDR  = 8'h19;
  localparam logic [7:0] REF_MASK  = 8'h0D;

  // counter bit index for a rate code on the system clock time base
  function automatic int sys_tap(input logic [1:0] code, input int base);
    case (code)
      2'b00:   return base;
      2'b01:   return base + 1;
      2'b10:   return base + 2;
      default: return base + 4;
    endcase
  endfunction

  // counter bit index for a rate code on the external time base (code 00 unused)
  function automatic int ext_tap(input logic [1:0] code);
    case (code)
      2'b01:   return 0;
      2'b10:   return 1;
      2'b11:   return 3;
      default: return 0;
    endcase
  endfunction

  // source field values that leave the system-clock chain without a clock
  function automatic logic src_halts(input logic [1:0] src_field);
    return src_field[1];
  endfunction

endpackage

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_rate_pkg::*;
#(
  parameter int GROUPS = 4,
  localparam int RATE_W = 2 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic [RATE_W-1:0] rate_cfg,
  output logic              use_sys,
  output clk_src_e          clk_src
);

  logic [RATE_W-1:0] rate_q;
  logic              sys_q;
  logic [1:0]        src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      sys_q  <= 1'b0;
      src_q  <= 2'b00;
    end else if (wr_en) begin
      if (wr_addr == RATE_ADDR) rate_q <= wr_data[RATE_W-1:0];
      if (wr_addr == REF_ADDR) begin
        sys_q <= wr_data[0];
        src_q <= wr_data[3:2];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == RATE_ADDR) rd_data[RATE_W-1:0] = rate_q;
    else if (rd_addr == REF_ADDR) rd_data = {4'b0000, src_q, 1'b0, sys_q};
  end

  assign rate_cfg = rate_q;
  assign use_sys  = sys_q;
  assign clk_src  = clk_src_e'(src_q);

endmodule

// File: rtl/flash_ext_sync.sv
module flash_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_level,
  output logic sync_rise
);

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      stage_q <= {stage_q[SYNC_STAGES-2:0], async_in};
      prev_q  <= stage_q[SYNC_STAGES-1];
    end
  end

  assign sync_level = stage_q[SYNC_STAGES-1];
  assign sync_rise  = stage_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/flash_divider.sv
module flash_divider
  import flash_rate_pkg::*;
#(
  parameter int GROUPS   = 4,
  parameter int SYS_BASE = 18,
  localparam int CNT_W   = SYS_BASE + 5,
  localparam int RATE_W  = 2 * GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              halted,
  input  logic              use_sys,
  input  logic              ext_level,
  input  logic [RATE_W-1:0] rate_cfg,
  output logic [CNT_W-1:0]  cnt,
  output logic [GROUPS-1:0] wave
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    logic [1:0] code;
    logic       tap_bit;
    assign code = rate_cfg[2*g +: 2];
    always_comb begin
      if (use_sys)           tap_bit = cnt_q[sys_tap(code, SYS_BASE)];
      else if (code == 2'b00) tap_bit = ext_level;
      else                    tap_bit = cnt_q[ext_tap(code)];
    end
    assign wave[g] = tap_bit & ~halted;
  end

endmodule

// File: rtl/flash_rate_gen.sv
module flash_rate_gen
  import flash_rate_pkg::*;
#(
  parameter int SYS_BASE = 18,
  localparam int GROUPS  = 4,
  localparam int CNT_W   = SYS_BASE + 5,
  localparam int RATE_W  = 2 * GROUPS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       ext_flash_in,
  output logic [3:0] flash_out
);

  logic [RATE_W-1:0] rate_cfg;
  logic              use_sys;
  clk_src_e          clk_src;
  logic              ext_level;
  logic              ext_rise;
  logic              halted;
  logic              advance;
  logic [CNT_W-1:0]  div_cnt;

  flash_cfg_regs #(.GROUPS(GROUPS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rate_cfg(rate_cfg), .use_sys(use_sys), .clk_src(clk_src)
  );

  flash_ext_sync #(.SYNC_STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(ext_flash_in),
    .sync_level(ext_level), .sync_rise(ext_rise)
  );

  assign halted  = use_sys & src_halts(clk_src);
  assign advance = use_sys ? ~halted : ext_rise;

  flash_divider #(.GROUPS(GROUPS), .SYS_BASE(SYS_BASE)) div_i (
    .clk(clk), .rst_n(rst_n), .step(advance), .halted(halted),
    .use_sys(use_sys), .ext_level(ext_level), .rate_cfg(rate_cfg),
    .cnt(div_cnt), .wave(flash_out)
  );

endmodule

// File: rtl/flash_rate_gen_chk.sv
module flash_rate_gen_chk #(
  parameter int CNT_W = 23
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic [3:0]       flash_out,
  input logic [7:0]       rate_cfg,
  input logic             use_sys,
  input logic             ext_rise,
  input logic             advance,
  input logic             halted,
  input logic [CNT_W-1:0] div_cnt
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (div_cnt == '0 && flash_out == 4'h0 && rate_cfg == 8'h00));

  assert_ref_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 8'h19) |-> ((rd_data & 8'hF2) == 8'h00));

  assert_ext_steps_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !use_sys |-> (advance == ext_rise));

  assert_no_step_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(div_cnt));

  assert_groups_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_cfg[1:0] == rate_cfg[3:2]) |-> (flash_out[0] == flash_out[1]));

  assert_write_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 8'h18 || wr_addr == 8'h19) && advance)
      |=> (div_cnt == $past(div_cnt) + 1'b1));

  assert_halt_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (flash_out == 4'h0));

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(div_cnt));

  assert_other_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr != 8'h18 && rd_addr != 8'h19) |-> (rd_data == 8'h00));

endmodule

bind flash_rate_gen flash_rate_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .flash_out(flash_out),
  .rate_cfg(rate_cfg), .use_sys(use_sys), .ext_rise(ext_rise),
  .advance(advance), .halted(halted), .div_cnt(div_cnt)
);

// File: tb/flash_rate_gen_tb.sv
module flash_rate_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 3;
  localparam int CW         = BASE + 5;
  localparam int CMOD       = 1 << CW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h18;
  logic [7:0] rd_data;
  logic       ext_flash_in = 1'b0;
  logic [3:0] flash_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  flash_rate_gen #(.SYS_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_flash_in(ext_flash_in), .flash_out(flash_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int   m_cnt = 0;
  int   m_rate = 0;
  int   m_ref = 0;
  int   m_hist[$] = '{0, 0, 0};  // [0] newest sample .. [2] oldest
  bit   m_in_reset = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rate = 0; m_ref = 0; m_hist = '{0, 0, 0}; m_in_reset = 1;
    end else begin
      bit sys;
      int src;
      bit step;
      m_in_reset = 0;
      sys = m_ref[0];
      src = (m_ref >> 2) & 3;
      if (sys) step = (src < 2);
      else     step = (m_hist[1] == 1) && (m_hist[2] == 0);
      if (step) m_cnt = (m_cnt + 1) % CMOD;
      m_hist.push_front(int'(ext_flash_in));
      void'(m_hist.pop_back());
      if (wr_en && wr_addr == 8'h18) m_rate = int'(wr_data);
      if (wr_en && wr_addr == 8'h19) m_ref = int'(wr_data) & 13;
    end
  end

  function automatic int bit_of(int v, int k);
    return (v / (1 << k)) % 2;
  endfunction

  function automatic int exp_wave();
    int r = 0;
    for (int g = 0; g < 4; g++) begin
      int code = (m_rate >> (2*g)) & 3;
      int lvl;
      if (m_ref % 2 == 1) begin
        int pw;
        pw = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 3 : 5;
        // period of 2^(BASE+pw) cycles: level is the bit of weight 2^(BASE+pw-1)
        lvl = (((m_ref >> 2) & 3) >= 2) ? 0 : bit_of(m_cnt, BASE + pw - 1);
      end else begin
        int edges_per_half;
        edges_per_half = (code == 1) ? 1 : (code == 2) ? 2 : 8;
        lvl = (code == 0) ? m_hist[1] : (m_cnt / edges_per_half) % 2;
      end
      r += lvl << g;
    end
    return r;
  endfunction

  function automatic int exp_rd(int a);
    if (a == 8'h18) return m_rate;
    if (a == 8'h19) return m_ref;
    return 0;
  endfunction

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done && rst_n) begin
      int ew;
      int er;
      string tag;
      ew = exp_wave();
      er = exp_rd(int'(rd_addr));
      if (m_ref % 2 == 1 && ((m_ref >> 2) & 3) >= 2) tag = "R8";
      else if (m_ref % 2 == 1) tag = "R5";
      else tag = "R4";
      checks++;
      if (int'(flash_out) != ew) begin
        failures++;
        $display("FAIL %s flash_out actual=%h expected=%h t=%0t", tag, flash_out, ew[3:0], $time);
      end
      if (rd_addr == 8'h18) tag = "R2";
      else if (rd_addr == 8'h19) tag = "R3";
      else tag = "R9";
      checks++;
      if (int'(rd_data) != er) begin
        failures++;
        $display("FAIL %s rd_data actual=%h expected=%h t=%0t", tag, rd_data, er[7:0], $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic write_reg(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ext_square(int half, int cycles);
    for (int i = 0; i < cycles; i++) begin
      ext_flash_in = ((i / half) % 2) == 1;
      tick(1);
    end
  endtask

  initial begin
    tick(3);
    #3;
    // R1: reset state at the ports
    rd_addr = 8'h18; #1 check_val("R1 rate reg", int'(rd_data), 0);
    rd_addr = 8'h19; #1 check_val("R1 ref reg", int'(rd_data), 0);
    check_val("R1 flash_out", int'(flash_out), 0);
    @(negedge clk); #2;
    rst_n = 1'b1;
    tick(1);

    // R2: all four codes at once, readback
    write_reg(8'h18, 8'hE4);
    rd_addr = 8'h18; #1 check_val("R2 readback", int'(rd_data), 8'hE4);

    // R3, R8: unused bits dropped, reserved source halts
    write_reg(8'h19, 8'hFF);
    rd_addr = 8'h19; #1 check_val("R3 masked readback", int'(rd_data), 8'h0D);
    tick(40);
    check_val("R8 halted low", int'(flash_out), 0);

    // R5: system clock, oscillator source
    write_reg(8'h19, 8'h05);
    tick(600);
    // R7: rate change while running
    rd_addr = 8'h18;
    write_reg(8'h18, 8'h1B);
    tick(300);
    // R8: no-clock source
    write_reg(8'h19, 8'h09);
    tick(50);
    check_val("R8 no-clock low", int'(flash_out), 0);
    write_reg(8'h19, 8'h01);
    tick(200);

    // R4: external time base, regular wave then irregular bursts
    write_reg(8'h19, 8'h00);
    write_reg(8'h18, 8'hE4);
    ext_square(3, 400);
    write_reg(8'h18, 8'h4E);  // R7 on external base
    for (int i = 0; i < 300; i++) begin
      ext_flash_in = ((i * 7 + i / 5) % 3) == 0;
      tick(1);
    end
    // source field 10 does not stop the external base
    write_reg(8'h19, 8'h08);
    ext_square(2, 200);

    // R9: foreign address writes ignored, reads zero
    write_reg(8'h20, 8'hAA);
    write_reg(8'h1A, 8'h55);
    rd_addr = 8'h18; #1 check_val("R9 rate untouched", int'(rd_data), 8'h4E);
    rd_addr = 8'h19; #1 check_val("R9 ref untouched", int'(rd_data), 8'h08);
    rd_addr = 8'h20; #1 check_val("R9 read zero", int'(rd_data), 0);
    tick(20);

    // R6: equal codes on two groups align
    write_reg(8'h18, 8'h05);
    ext_square(1, 60);
    check_val("R6 aligned", int'(flash_out[0]), int'(flash_out[1]));

    // R1: reset mid-run
    rst_n = 1'b0;
    tick(2);
    rd_addr = 8'h18; #1 check_val("R1 reset mid-run", int'(rd_data), 0);
    check_val("R1 outputs low", int'(flash_out), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule